// File: doc/BRIEF.md
# Die Temperature Heater Regulator

This block holds die temperature roughly constant by dissipating switching power on the die itself. An on-chip sensor converter delivers periodic temperature codes, each marked by a one-cycle valid strobe. The regulator compares each sample with a programmable setpoint and adjusts a heat level. Heat is produced by four equal groups of toggle flip-flops. Power is set by how many groups toggle, while the clock that drives them stays the same.

Two control styles are available through a static mode input. Stepped mode keeps a 2-bit heat word, and the value N of that word enables exactly N groups. On/off mode behaves as a bang-bang thermostat that drives all four groups or none. In both modes a hysteresis band around the setpoint prevents chatter. A separate over-temperature limit shuts every group off as soon as a sample exceeds it. An XOR-folded copy of the heater flops is brought to a port, so the flops have a load and remain observable.

Top module: `die_heat_regulator`

## Requirements
- R1: A synchronous reset, active high, clears the heat word to 0 and the on/off state to off. It also clears all heater flops to 0, so `group_en` and `heat_obs` read all zeros on the cycle after reset.
- R2: In stepped mode (`mode_onoff` = 0), a heat word of N drives `group_en` bits 0 to N-1 high and every other bit low.
- R3: In stepped mode, a valid sample is cold when code + hysteresis < setpoint. A cold sample that is not over the limit raises the heat word by exactly one, saturating at 3. The new word is visible on the clock edge that captures the sample.
- R4: In stepped mode, a valid sample is warm when code > setpoint + hysteresis. A warm sample that is not over the limit lowers the heat word by exactly one, saturating at 0. These comparisons use arithmetic wider than the code, so a sum that overflows the code width does not wrap.
- R5: The heat word and the on/off state do not change on cycles without a valid strobe, or on valid samples inside the closed band setpoint ± hysteresis.
- R6: In on/off mode (`mode_onoff` = 1), a cold sample turns the thermostat on and a warm sample turns it off. On drives `group_en` to 4'b1111 and off drives it to 4'b0000. The stepped heat word holds its value while this mode is selected.
- R7: A valid sample with code > `over_limit` clears both the heat word and the on/off state, whatever the mode, so `group_en` is 0 after that edge. This check takes priority over the cold comparison.
- R8: Each heater group inverts all of its flops on every clock edge at which its enable bit is high, and holds them otherwise. Bit b of `heat_obs` is the XOR of bit b across all four groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the regulator and the heater flops |
| rst | input | 1 | Synchronous reset, active high |
| temp_code | input | TEMP_W | Temperature code from the sensor converter |
| temp_valid | input | 1 | One-cycle strobe marking a new temperature code |
| setpoint | input | TEMP_W | Target temperature code (static) |
| hyst_band | input | TEMP_W | Half-width of the dead band around the setpoint (static) |
| over_limit | input | TEMP_W | Codes above this value force all heat off (static) |
| mode_onoff | input | 1 | 0 selects stepped control, 1 selects on/off thermostat (static) |
| heat_word | output | 2 | Current stepped heat level |
| group_en | output | 4 | Toggle enable for each heater group |
| heat_obs | output | GROUP_W | XOR fold of the four heater groups |

## Verification
The bench builds the regulator with an 8-bit temperature code and 5 flops per group. With codes this narrow, a setpoint near 255 plus a hysteresis of 10 overflows the code width, and the bench uses this to show that the widened band comparison does not wrap. It also places over-limit samples at the top of the code range. Because each group has only five flops, the bench can compare every bit of the folded observation output against a per-group toggle-parity model. It does this through long enabled and disabled stretches, across mode switches, and at the band edges exactly at setpoint ± hysteresis.

// File: rtl/heatreg_pkg.sv
package heatreg_pkg;

    localparam int NUM_GROUPS = 4;
    localparam int LEVEL_W    = 2;

    typedef logic [LEVEL_W-1:0] level_t;

    localparam level_t LEVEL_MAX = level_t'(NUM_GROUPS - 1);

    typedef enum logic {
        MODE_STEPPED = 1'b0,
        MODE_ONOFF   = 1'b1
    } reg_mode_e;

    typedef enum logic [1:0] {
        SMP_HOLD = 2'd0,
        SMP_COLD = 2'd1,
        SMP_WARM = 2'd2,
        SMP_TRIP = 2'd3
    } sample_cls_e;

    typedef struct packed {
        level_t level;
        logic   therm_on;
    } ctrl_state_t;

endpackage

// File: rtl/heat_sample_classify.sv
module heat_sample_classify
    import heatreg_pkg::*;
#(
    parameter int TEMP_W = 12
) (
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] setpoint,
    input  logic [TEMP_W-1:0] hyst_band,
    input  logic [TEMP_W-1:0] over_limit,
    output sample_cls_e       sample_cls
);

    localparam int WIDE_W = TEMP_W + 1;

    logic [WIDE_W-1:0] code_w;
    logic [WIDE_W-1:0] low_edge_w;
    logic [WIDE_W-1:0] high_edge_w;
    logic              is_trip;
    logic              is_cold;
    logic              is_warm;

    always_comb begin
        code_w      = {1'b0, temp_code};
        low_edge_w  = code_w + {1'b0, hyst_band};
        high_edge_w = {1'b0, setpoint} + {1'b0, hyst_band};
        is_trip     = temp_code > over_limit;
        is_cold     = low_edge_w < {1'b0, setpoint};
        is_warm     = code_w > high_edge_w;
        if (is_trip) begin
            sample_cls = SMP_TRIP;
        end else if (is_cold) begin
            sample_cls = SMP_COLD;
        end else if (is_warm) begin
            sample_cls = SMP_WARM;
        end else begin
            sample_cls = SMP_HOLD;
        end
    end

endmodule

// File: rtl/heat_level_ctrl.sv
module heat_level_ctrl
    import heatreg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sample_valid,
    input  sample_cls_e           sample_cls,
    input  logic                  mode_onoff,
    output level_t                level_out,
    output logic [NUM_GROUPS-1:0] group_en
);

    ctrl_state_t st_d, st_q;
    reg_mode_e   mode;

    assign mode = reg_mode_e'(mode_onoff);

    always_comb begin
        st_d = st_q;
        if (sample_valid) begin
            unique case (sample_cls)
                SMP_TRIP: st_d = '0;
                SMP_COLD: begin
                    if (mode == MODE_ONOFF) begin
                        st_d.therm_on = 1'b1;
                    end else if (st_q.level != LEVEL_MAX) begin
                        st_d.level = st_q.level + level_t'(1);
                    end
                end
                SMP_WARM: begin
                    if (mode == MODE_ONOFF) begin
                        st_d.therm_on = 1'b0;
                    end else if (st_q.level != '0) begin
                        st_d.level = st_q.level - level_t'(1);
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_en
            always_comb begin
                if (mode == MODE_ONOFF) begin
                    group_en[g] = st_q.therm_on;
                end else begin
                    group_en[g] = ({1'b0, st_q.level} > (LEVEL_W+1)'(g));
                end
            end
        end
    endgenerate

    assign level_out = st_q.level;

endmodule

// File: rtl/heater_bank.sv
module heater_bank
    import heatreg_pkg::*;
#(
    parameter int GROUP_W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_GROUPS-1:0] group_en,
    output logic [GROUP_W-1:0]    heat_obs
);

    typedef logic [NUM_GROUPS-1:0][GROUP_W-1:0] bank_t;

    bank_t bank_d, bank_q;

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            always_comb begin
                bank_d[g] = group_en[g] ? ~bank_q[g] : bank_q[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        heat_obs = '0;
        for (int k = 0; k < NUM_GROUPS; k++) begin
            heat_obs = heat_obs ^ bank_q[k];
        end
    end

endmodule

// File: rtl/die_heat_regulator.sv
module die_heat_regulator
    import heatreg_pkg::*;
#(
    parameter int TEMP_W  = 12,
    parameter int GROUP_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TEMP_W-1:0]  temp_code,
    input  logic               temp_valid,
    input  logic [TEMP_W-1:0]  setpoint,
    input  logic [TEMP_W-1:0]  hyst_band,
    input  logic [TEMP_W-1:0]  over_limit,
    input  logic               mode_onoff,
    output logic [1:0]         heat_word,
    output logic [3:0]         group_en,
    output logic [GROUP_W-1:0] heat_obs
);

    sample_cls_e           cls;
    level_t                level;
    logic [NUM_GROUPS-1:0] en;

    heat_sample_classify #(.TEMP_W(TEMP_W)) u_classify (
        .temp_code  (temp_code),
        .setpoint   (setpoint),
        .hyst_band  (hyst_band),
        .over_limit (over_limit),
        .sample_cls (cls)
    );

    heat_level_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (temp_valid),
        .sample_cls   (cls),
        .mode_onoff   (mode_onoff),
        .level_out    (level),
        .group_en     (en)
    );

    heater_bank #(.GROUP_W(GROUP_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .group_en (en),
        .heat_obs (heat_obs)
    );

    assign heat_word = level;
    assign group_en  = en;

endmodule

// File: rtl/heatreg_chk.sv
module heatreg_chk #(
    parameter int TEMP_W  = 12,
    parameter int GROUP_W = 64
) (
    input logic               clk,
    input logic               rst,
    input logic [TEMP_W-1:0]  temp_code,
    input logic               temp_valid,
    input logic [TEMP_W-1:0]  over_limit,
    input logic               mode_onoff,
    input logic [1:0]         heat_word,
    input logic [3:0]         group_en,
    input logic [GROUP_W-1:0] heat_obs
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (heat_word == 2'd0 && group_en == 4'd0 && heat_obs == '0));

    // R2
    stepped_count_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_onoff |-> ($countones(group_en) == int'(heat_word)
                         && ((group_en & (group_en + 4'd1)) == 4'd0)));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (int'(heat_word) - int'($past(heat_word)) <= 1)
        && (int'($past(heat_word)) - int'(heat_word) <= 1 || heat_word == 2'd0));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$past(temp_valid) |-> $stable(heat_word));

    // R6
    onoff_all_or_none_chk: assert property (@(posedge clk) disable iff (rst)
        mode_onoff |-> (group_en == 4'd0 || group_en == 4'hF));

    // R7
    over_limit_off_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(temp_valid && (temp_code > over_limit)) |-> (group_en == 4'd0));

    // R8
    idle_bank_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($past(group_en) == 4'd0) |-> $stable(heat_obs));

endmodule

bind die_heat_regulator heatreg_chk #(.TEMP_W(TEMP_W), .GROUP_W(GROUP_W)) u_heatreg_chk (
    .clk        (clk),
    .rst        (rst),
    .temp_code  (temp_code),
    .temp_valid (temp_valid),
    .over_limit (over_limit),
    .mode_onoff (mode_onoff),
    .heat_word  (heat_word),
    .group_en   (group_en),
    .heat_obs   (heat_obs)
);

// File: tb/test_die_heat_regulator.sv
`timescale 1ns/1ps
module test_die_heat_regulator;

    localparam int TW = 8;
    localparam int GW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] temp_code = '0;
    logic          temp_valid = 1'b0;
    logic [TW-1:0] setpoint = 8'd100;
    logic [TW-1:0] hyst_band = 8'd4;
    logic [TW-1:0] over_limit = 8'd200;
    logic          mode_onoff = 1'b0;
    logic [1:0]    heat_word;
    logic [3:0]    group_en;
    logic [GW-1:0] heat_obs;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    int m_lvl = 0;
    bit m_on  = 1'b0;
    bit m_grp [4];

    always #2 clk = ~clk;

    die_heat_regulator #(.TEMP_W(TW), .GROUP_W(GW)) i_die_heat_regulator (
        .clk(clk), .rst(rst), .temp_code(temp_code), .temp_valid(temp_valid),
        .setpoint(setpoint), .hyst_band(hyst_band), .over_limit(over_limit),
        .mode_onoff(mode_onoff), .heat_word(heat_word), .group_en(group_en),
        .heat_obs(heat_obs)
    );

    function automatic int model_en();
        if (mode_onoff) return m_on ? 15 : 0;
        return (1 << m_lvl) - 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lvl = 0;
            m_on  = 1'b0;
            for (int g = 0; g < 4; g++) m_grp[g] = 1'b0;
        end else begin
            int en;
            int t, sp, h, lim;
            en = model_en();
            for (int g = 0; g < 4; g++) if (en[g]) m_grp[g] = ~m_grp[g];
            if (temp_valid) begin
                t = temp_code; sp = setpoint; h = hyst_band; lim = over_limit;
                if (t > lim) begin
                    m_lvl = 0; m_on = 1'b0;
                end else if (t + h < sp) begin
                    if (mode_onoff) m_on = 1'b1;
                    else if (m_lvl < 3) m_lvl++;
                end else if (t > sp + h) begin
                    if (mode_onoff) m_on = 1'b0;
                    else if (m_lvl > 0) m_lvl--;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            logic [GW-1:0] exp_obs;
            logic [3:0]    exp_en;
            bit            par;
            par = m_grp[0] ^ m_grp[1] ^ m_grp[2] ^ m_grp[3];
            exp_obs = par ? '1 : '0;
            exp_en = 4'(model_en());
            n_vec++;
            if (heat_word !== 2'(m_lvl)) begin
                n_bad++;
                $display("FAIL %s heat_word actual=%0d expected=%0d t=%0t", cur_req, heat_word, m_lvl, $time);
            end
            if (group_en !== exp_en) begin
                n_bad++;
                $display("FAIL %s group_en actual=%b expected=%b t=%0t",
                         mode_onoff ? "R6" : "R2", group_en, exp_en, $time);
            end
            if (heat_obs !== exp_obs) begin
                n_bad++;
                $display("FAIL R8 heat_obs actual=%b expected=%b t=%0t", heat_obs, exp_obs, $time);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sample(input int code);
        @(posedge clk); #1;
        temp_code  = 8'(code);
        temp_valid = 1'b1;
        @(posedge clk); #1;
        temp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog expired");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst = 1'b0;
        idle(4);

        // R3 and R2: cold samples climb and saturate
        cur_req = "R3";
        sample(50); idle(3);
        sample(50); idle(3);
        sample(95); idle(3);       // just below band edge: cold
        sample(50); idle(3);       // saturation at 3
        cur_req = "R2";
        idle(6);

        // R5: band edges and in-band hold
        cur_req = "R5";
        sample(96); idle(2);
        sample(104); idle(2);
        sample(100); idle(5);

        // R4: warm samples descend and saturate
        cur_req = "R4";
        sample(105); idle(2);
        sample(150); idle(4);
        sample(105); idle(2);
        sample(105); idle(2);      // saturation at 0
        idle(4);

        // R8: long stretch with two groups enabled, then idle
        cur_req = "R8";
        sample(10); sample(10);
        idle(11);
        sample(200); idle(3);      // equal to limit: warm, not trip
        idle(7);

        // R7: over-limit trip in stepped mode, priority over cold
        cur_req = "R7";
        sample(10); sample(10); sample(10); idle(2);
        sample(201); idle(3);
        sample(30); idle(2);
        sample(255); idle(3);

        // R6: on/off thermostat
        cur_req = "R6";
        sample(10); idle(2);       // stepped level 1 kept
        @(posedge clk); #1; mode_onoff = 1'b1;
        idle(2);
        sample(20); idle(5);
        sample(100); idle(3);
        sample(104); idle(3);
        sample(110); idle(3);
        sample(20); idle(3);
        cur_req = "R7";
        sample(230); idle(3);      // trip in on/off mode
        cur_req = "R6";
        sample(20); idle(3);
        @(posedge clk); #1; mode_onoff = 1'b0;   // level cleared by trip
        idle(3);

        // R4: widened band comparison near the top of the code range
        cur_req = "R4";
        @(posedge clk); #1;
        setpoint = 8'd250; hyst_band = 8'd10; over_limit = 8'd255;
        sample(239); idle(2);      // 249 < 250: cold
        sample(255); idle(3);      // 255 > 260 false: hold
        sample(240); idle(3);      // 250 < 250 false: hold

        // R1: reset from an active state
        cur_req = "R1";
        sample(10); idle(2);
        @(posedge clk); #1; rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule